// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Output

This block shifts or rotates a data word by an amount held in a register, and returns both the shifted word and the carry flag that the operation produces. It handles four operations: logical left, logical right, arithmetic right and rotate right. The amount comes in as a full register, but only its low byte counts. Because of this, amounts from 0 to 255 can reach the unit, and each operation has its own rule for amounts at or beyond the word width.

The datapath is purely combinational. A parameter can place one register stage on the outputs, so the block fits into a pipelined execute stage. When that stage is present, results appear one clock after their operands. An amount of zero passes both the word and the incoming carry through unchanged. This lets the caller feed every register-shift through the unit without any special case.

Top module: `regshift_unit`

## Requirements
- R1: Only bits [7:0] of `in_amount` form the shift amount n; bits above 7 have no effect on either output.
- R2: When n is 0, for every shift kind, `out_value` equals `in_value` and `out_carry` equals `in_carry`.
- R3: Kind 2'b00 (logical left) with n from 1 to 31 gives `in_value << n`, and the carry is `in_value` bit (32 - n).
- R4: Kind 2'b01 (logical right) with n from 1 to 31 gives `in_value >> n`, and the carry is `in_value` bit (n - 1).
- R5: With n exactly 32, logical right gives 0 with carry `in_value[31]`, and logical left gives 0 with carry `in_value[0]`.
- R6: Kind 2'b10 (arithmetic right) with n from 1 to 31 gives the sign-extending shift with carry bit (n - 1); with n of 32 or more it gives 32 copies of `in_value[31]` with carry `in_value[31]`.
- R7: Kind 2'b11 (rotate right) uses s = n[4:0]. When s is nonzero the result is `(in_value >> s) | (in_value << (32 - s))` and the carry is bit (s - 1).
- R8: Rotate right with n nonzero but n[4:0] zero leaves the word unchanged and sets the carry to `in_value[31]`.
- R9: Logical left and logical right with n above 32 give result 0 and carry 0.
- R10: With `OUT_REG` = 1, both outputs update on the rising clock edge following their operands. An active-low asynchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| in_value | input | 32 | Word to be shifted |
| in_amount | input | 32 | Amount register; only the low byte is used |
| in_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| in_carry | input | 1 | Current carry flag |
| out_value | output | 32 | Shifted or rotated word |
| out_carry | output | 1 | Updated carry flag |

## Verification
The clocked properties assume that operands stay stable across each rising edge, so the combinational result sampled at an edge is the one captured by the output stage. The bench changes operands only on falling edges to respect this. The bench sweeps every low-byte amount from 0 to 255 against all four kinds, both carry-in values and a set of words chosen for sign and edge bits. Half of the sweep sets nonzero upper amount bits, so that the amount truncation is exercised on every kind and amount.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

   // Operation selector; the two-bit codes are fixed by the requirements.
   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shift_kind_e;

endpackage

// File: rtl/regshift_amount_decode.sv
// Classifies the used part of the amount register against the word width.
module regshift_amount_decode #(
   parameter int DATA_W     = 32,
   parameter int AMT_USED_W = 8,
   localparam int SHW       = $clog2(DATA_W)
) (
   input  logic [AMT_USED_W-1:0] amt,
   output logic                  amt_zero,
   output logic                  amt_exact,
   output logic                  amt_over,
   output logic [SHW-1:0]        amt_low
);
   localparam logic [AMT_USED_W-1:0] WIDTH_CODE = AMT_USED_W'(DATA_W);

   if (DATA_W >= (1 << AMT_USED_W)) begin : g_bad_amt
      $error("amount field too narrow to express the word width");
   end

   always_comb begin
      amt_zero  = (amt == '0);
      amt_exact = (amt == WIDTH_CODE);
      amt_over  = (amt >  WIDTH_CODE);
      amt_low   = amt[SHW-1:0];
   end
endmodule

// File: rtl/regshift_core.sv
// In-range datapath: one logarithmic rotator serves all four kinds.
// Left shifts are done by bit-reversing the word around the rotator.
module regshift_core
   import regshift_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SHW   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] value,
   input  shift_kind_e       kind,
   input  logic [SHW-1:0]    amt_low,
   output logic [DATA_W-1:0] result,
   output logic              carry_small
);
   logic [DATA_W-1:0] value_rev;
   logic [DATA_W-1:0] stage [SHW+1];
   logic [DATA_W-1:0] rot;
   logic [DATA_W-1:0] rot_rev_masked;
   logic [DATA_W-1:0] keep_mask;
   logic [DATA_W-1:0] fill;
   logic [DATA_W-1:0] right_res;
   logic [DATA_W-1:0] masked;

   // bit reversal of the input word
   for (genvar b = 0; b < DATA_W; b++) begin : g_rev_in
      assign value_rev[b] = value[DATA_W-1-b];
   end

   assign stage[0] = (kind == SK_LSL) ? value_rev : value;

   // rotate-right stages, stage k moves by 2**k when its amount bit is set
   for (genvar k = 0; k < SHW; k++) begin : g_rot
      localparam int STEP = 1 << k;
      assign stage[k+1] = amt_low[k]
                        ? {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]}
                        : stage[k];
   end

   assign rot       = stage[SHW];
   assign keep_mask = {DATA_W{1'b1}} >> amt_low;
   assign masked    = rot & keep_mask;
   assign fill      = (kind == SK_ASR && value[DATA_W-1]) ? ~keep_mask : '0;
   assign right_res = masked | fill;

   // undo the reversal for left shifts
   for (genvar b = 0; b < DATA_W; b++) begin : g_rev_out
      assign rot_rev_masked[b] = masked[DATA_W-1-b];
   end

   always_comb begin
      unique case (kind)
         SK_LSL:         result = rot_rev_masked;
         SK_LSR, SK_ASR: result = right_res;
         default:        result = rot;
      endcase
   end

   // the last bit moved out always lands in the top position of the rotator
   assign carry_small = rot[DATA_W-1];
endmodule

// File: rtl/regshift_select.sv
// Applies the zero-amount and out-of-range rules over the core result.
module regshift_select
   import regshift_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] value,
   input  logic              carry_in,
   input  shift_kind_e       kind,
   input  logic              amt_zero,
   input  logic              amt_exact,
   input  logic              amt_over,
   input  logic [DATA_W-1:0] small_res,
   input  logic              small_carry,
   output logic [DATA_W-1:0] res,
   output logic              carry
);
   logic sign_bit;
   assign sign_bit = value[DATA_W-1];

   always_comb begin
      res   = small_res;
      carry = small_carry;
      if (amt_zero) begin
         res   = value;
         carry = carry_in;
      end else begin
         unique case (kind)
            SK_LSL: begin
               if (amt_exact) begin
                  res   = '0;
                  carry = value[0];
               end else if (amt_over) begin
                  res   = '0;
                  carry = 1'b0;
               end
            end
            SK_LSR: begin
               if (amt_exact) begin
                  res   = '0;
                  carry = sign_bit;
               end else if (amt_over) begin
                  res   = '0;
                  carry = 1'b0;
               end
            end
            SK_ASR: begin
               if (amt_exact || amt_over) begin
                  res   = {DATA_W{sign_bit}};
                  carry = sign_bit;
               end
            end
            default: ; // rotate: core output covers every nonzero amount
         endcase
      end
   end
endmodule

// File: rtl/regshift_unit.sv
module regshift_unit
   import regshift_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int AMT_REG_W  = 32,
   parameter int AMT_USED_W = 8,
   parameter bit OUT_REG    = 1'b1,
   localparam int SHW       = $clog2(DATA_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    in_value,
   input  logic [AMT_REG_W-1:0] in_amount,
   input  logic [1:0]           in_kind,
   input  logic                 in_carry,
   output logic [DATA_W-1:0]    out_value,
   output logic                 out_carry
);
   if (DATA_W != (1 << SHW) || DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (AMT_REG_W <= AMT_USED_W) begin : g_bad_amt_reg
      $error("amount register must be wider than its used field");
   end

   shift_kind_e           kind;
   logic [AMT_USED_W-1:0] amt;
   logic                  amt_zero, amt_exact, amt_over;
   logic [SHW-1:0]        amt_low;
   logic [DATA_W-1:0]     small_res, res_c;
   logic                  small_carry, carry_c;
   logic                  amt_unused_bits;

   assign kind            = shift_kind_e'(in_kind);
   assign amt             = in_amount[AMT_USED_W-1:0];
   assign amt_unused_bits = ^in_amount[AMT_REG_W-1:AMT_USED_W];

   regshift_amount_decode #(.DATA_W(DATA_W), .AMT_USED_W(AMT_USED_W)) u_dec (
      .amt      (amt),
      .amt_zero (amt_zero),
      .amt_exact(amt_exact),
      .amt_over (amt_over),
      .amt_low  (amt_low)
   );

   regshift_core #(.DATA_W(DATA_W)) u_core (
      .value      (in_value),
      .kind       (kind),
      .amt_low    (amt_low),
      .result     (small_res),
      .carry_small(small_carry)
   );

   regshift_select #(.DATA_W(DATA_W)) u_sel (
      .value      (in_value),
      .carry_in   (in_carry),
      .kind       (kind),
      .amt_zero   (amt_zero),
      .amt_exact  (amt_exact),
      .amt_over   (amt_over),
      .small_res  (small_res),
      .small_carry(small_carry),
      .res        (res_c),
      .carry      (carry_c)
   );

   if (OUT_REG) begin : g_out_reg
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_value <= '0;
            out_carry <= 1'b0;
            primed    <= 1'b0;
         end else begin
            out_value <= res_c;
            out_carry <= carry_c;
            primed    <= 1'b1;
         end
      end

      // R10: the output stage carries a zero-amount operand one edge later
      p_out_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
         primed && ($past(in_amount[AMT_USED_W-1:0]) == '0)
         |-> (out_value == $past(in_value)) && (out_carry == $past(in_carry)));
   end else begin : g_out_comb
      assign out_value = res_c;
      assign out_carry = carry_c;
   end

   // R2: a zero amount keeps word and carry
   p_zero_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (amt == '0) |-> (res_c == in_value) && (carry_c == in_carry));

   // R6: large arithmetic shifts saturate to the sign
   p_asr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_ASR) && (amt >= AMT_USED_W'(DATA_W))
      |-> (res_c == {DATA_W{in_value[DATA_W-1]}}) && (carry_c == in_value[DATA_W-1]));

   // R9: logical shifts beyond the width clear both outputs
   p_beyond_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind == SK_LSL) || (kind == SK_LSR)) && (amt > AMT_USED_W'(DATA_W))
      |-> (res_c == '0) && !carry_c);

   // R5: exact-width logical right keeps only the old top bit as carry
   p_lsr_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_LSR) && (amt == AMT_USED_W'(DATA_W))
      |-> (res_c == '0) && (carry_c == in_value[DATA_W-1]));

   // R7: a rotation never changes the population count
   p_rot_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_ROR) |-> ($countones(res_c) == $countones(in_value)));

   // R8: a whole-word rotation returns the word and its top bit as carry
   p_rot_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SK_ROR) && (amt != '0) && (amt[SHW-1:0] == '0)
      |-> (res_c == in_value) && (carry_c == in_value[DATA_W-1]));
endmodule

// File: tb/regshift_unit_test.sv
`timescale 1ns/1ps
module regshift_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_value = '0;
   logic [31:0] in_amount = '0;
   logic [1:0]  in_kind = 2'b00;
   logic        in_carry = 1'b0;
   logic [31:0] out_value;
   logic        out_carry;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk; // 250 MHz

   regshift_unit uut (
      .clk(clk), .rst_n(rst_n), .in_value(in_value), .in_amount(in_amount),
      .in_kind(in_kind), .in_carry(in_carry),
      .out_value(out_value), .out_carry(out_carry)
   );

   task automatic check(input string tag, input logic [31:0] gr, input logic gc,
                        input logic [31:0] er, input logic ec);
      checks++;
      if (gr !== er || gc !== ec) begin
         errors++;
         $display("FAIL %s value=%h carry=%b expected value=%h carry=%b (kind=%b amt=%h in=%h cin=%b)",
                  tag, gr, gc, er, ec, in_kind, in_amount, in_value, in_carry);
      end
   endtask

   // Reference model written from the requirements with plain operators.
   task automatic model(input logic [31:0] x, input logic [31:0] a, input logic [1:0] k,
                        input logic c, output logic [31:0] r, output logic co,
                        output string tag);
      int n;
      int s;
      n = int'(a[7:0]);
      s = n % 32;
      if (n == 0) begin
         r = x; co = c; tag = "R2";
      end else begin
         case (k)
            2'b00: if (n < 32) begin r = x << n; co = x[32-n]; tag = "R3"; end
                   else if (n == 32) begin r = '0; co = x[0]; tag = "R5"; end
                   else begin r = '0; co = 1'b0; tag = "R9"; end
            2'b01: if (n < 32) begin r = x >> n; co = x[n-1]; tag = "R4"; end
                   else if (n == 32) begin r = '0; co = x[31]; tag = "R5"; end
                   else begin r = '0; co = 1'b0; tag = "R9"; end
            2'b10: if (n < 32) begin r = 32'($signed(x) >>> n); co = x[n-1]; tag = "R6"; end
                   else begin r = {32{x[31]}}; co = x[31]; tag = "R6"; end
            default: if (s == 0) begin r = x; co = x[31]; tag = "R8"; end
                     else begin r = (x >> s) | (x << (32 - s)); co = x[s-1]; tag = "R7"; end
         endcase
      end
   endtask

   logic [31:0] vals [6] = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000,
                             32'h1234_5678, 32'hA5C3_0F96, 32'h7FFF_FFFE};

   initial begin
      #700000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] er;
      logic        ec;
      string       tag;
      in_value  = 32'hDEAD_BEEF;
      in_amount = 32'h1;
      in_carry  = 1'b1;
      repeat (3) @(posedge clk);
      #1 check("R10 reset", out_value, out_carry, 32'h0, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      // R10: output holds its registered value until the next rising edge
      in_kind = 2'b00; in_amount = 32'd0; in_value = 32'h0BAD_F00D; in_carry = 1'b1;
      @(posedge clk); @(negedge clk);
      in_value = 32'h1111_2222; in_carry = 1'b0;
      #1 check("R10 hold", out_value, out_carry, 32'h0BAD_F00D, 1'b1);
      @(posedge clk); @(negedge clk);
      check("R10 update", out_value, out_carry, 32'h1111_2222, 1'b0);

      for (int i = 0; i < 6; i++) begin
         for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 256; n++) begin
               for (int c = 0; c < 2; c++) begin
                  in_value  = vals[i];
                  in_kind   = 2'(k);
                  in_carry  = c[0];
                  // R1: odd passes put nonzero bits above the used byte
                  in_amount = (c == 1) ? {24'h5A5A01 ^ 24'(n * 7 + i), 8'(n)} : 32'(n);
                  model(in_value, in_amount, in_kind, in_carry, er, ec, tag);
                  if (c == 1) tag = {tag, " R1"};
                  @(posedge clk); @(negedge clk);
                  check(tag, out_value, out_carry, er, ec);
               end
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule